// File: doc/BRIEF.md
# Weighted Score Accumulator

This block is the last stage of a Gaussian scoring datapath. Each frame's score is updated as score = score + sum * scale + weight, in a compact floating-point format. Upstream logic delivers one component sum per frame. Sums for one component arrive as a burst covering every frame, and components follow one another until a full group is done. A single fused multiply-add chain serves all frames in interleaved order. Each frame has its own score register, so an update for a frame lands well before that frame's next input.

When the last component of a group has been folded in, the block converts each frame score to IEEE 754 single format. It writes the scores into a small result FIFO in frame order, and a host pops them one word at a time. The scale and weight belong to a component, and the block captures them from the first beat of that component's burst. The stage registers load only when a beat moves through them, so the datapath holds still while no input arrives. Input is held off whenever the FIFO could not take a whole group of results.

Top module: `weighted_score_acc`

## Requirements
- R1: For every frame f, the delivered result equals the sum over all 8 components c of sum[c][f] * scale[c] + weight[c]. When every operand and every intermediate value has at most 13 significant bits, the result is exact. Otherwise each of the two fused steps truncates toward zero.
- R2: Input operands are 21 bits wide: bit 20 is the sign, bits 19:12 are the exponent with bias 127 (exponent 0 means zero), and bits 11:0 are the fraction under a hidden one. A result word is {sign, exponent, fraction, 11 zero bits}. An exact zero is all zeros.
- R3: A group consists of 80 accepted beats: frames 0 to 9 of component 0, then frames 0 to 9 of component 1, and so on up to component 7.
- R4: The first component of a group overwrites each frame score. No value from an earlier group affects a later one.
- R5: Scale and weight are taken from the frame-0 beat of each component. Their values on frames 1 to 9 of that component have no effect.
- R6: After the 80th beat, the ten results enter the FIFO in frame order 0 to 9.
- R7: in_ready is low from the 80th beat until the results are queued. It is also low at the start of a group while the 16-entry FIFO has fewer than 10 free entries. A beat offered while in_ready is low is not consumed.
- R8: out_data shows the oldest queued word while out_empty is low. out_pop advances it. A pop while out_empty is high has no effect.
- R9: Idle cycles between beats (in_valid low) do not change any result, and the stage registers hold their values during them.
- R10: A frame whose terms cancel exactly yields the word 0x00000000. A negative total sets bit 31.
- R11: After reset, out_empty and in_ready are high, and the next beat is frame 0 of component 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A component sum is offered |
| in_ready | output | 1 | The offered sum is taken at this edge |
| in_sum | input | 21 | Component sum for the current frame |
| in_scale | input | 21 | Component scale, used from the frame-0 beat |
| in_weight | input | 21 | Component weight, used from the frame-0 beat |
| out_pop | input | 1 | Remove the head result |
| out_empty | output | 1 | No result is queued |
| out_data | output | 32 | Head result in IEEE single format |

## Verification
The bench repeats groups so that stale scores would show. A design that added the first component onto leftover registers would report the previous group's totals mixed into the new ones. It scrambles scale and weight on every beat but the first of a component. A design that sampled them on each beat would return wrong values for frames 1 to 9. It fills the FIFO to six free entries and then offers a beat while in_ready is low. A design that consumed that beat, or that overflowed the FIFO, would shift every later frame. Cancelling weights and all-negative weights check the zero encoding and the sign bit, and random idle gaps check that the pipeline does not advance without input.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  parameter int EXP_W    = 8;
  parameter int MAN_W    = 12;
  parameter int FP_W     = 1 + EXP_W + MAN_W;
  parameter int EXP_BIAS = 127;
  parameter int IEEE_W   = 32;
  parameter int IEEE_MAN = 23;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } rfloat_t;

  typedef enum logic [1:0] {ST_ACCUM, ST_FLUSH, ST_DRAIN} seq_state_t;

  localparam rfloat_t RF_ONE = '{sign: 1'b0, exp: EXP_W'(EXP_BIAS), man: '0};

  // Widen the fraction with zeros; exponent and bias match single format.
  function automatic logic [IEEE_W-1:0] to_ieee(rfloat_t v);
    return {v.sign, v.exp, v.man, {(IEEE_MAN-MAN_W){1'b0}}};
  endfunction
endpackage

// File: rtl/rf_fma.sv
// Combinational y = a * b + c in the reduced format, one truncation at the end.
module rf_fma
  import wsa_pkg::*;
#(
  parameter int ALIGN_LIM = 40
) (
  input  rfloat_t a,
  input  rfloat_t b,
  input  rfloat_t c,
  output rfloat_t y
);
  localparam int SIG_W  = MAN_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int ACC_W  = PROD_W + ALIGN_LIM + 6;
  localparam int BASE_W = EXP_W + 6;
  localparam logic signed [BASE_W-1:0] PROD_OFF = BASE_W'(2 * EXP_BIAS + 2 * MAN_W);
  localparam logic signed [BASE_W-1:0] C_OFF    = BASE_W'(EXP_BIAS + MAN_W);
  localparam logic signed [BASE_W-1:0] LIM_S    = BASE_W'(ALIGN_LIM);

  logic [SIG_W-1:0]         sig_a, sig_b, sig_c;
  logic [PROD_W-1:0]        prod;
  logic signed [BASE_W-1:0] bot_p, bot_c, bot_p_e, bot_c_e, diff, base;
  logic [ACC_W-1:0]         term_p, term_c, acc, mag;
  logic                     neg;
  int                       lead;
  int                       e_res;

  assign sig_a = (a.exp != '0) ? {1'b1, a.man} : '0;
  assign sig_b = (b.exp != '0) ? {1'b1, b.man} : '0;
  assign sig_c = (c.exp != '0) ? {1'b1, c.man} : '0;
  assign prod  = sig_a * sig_b;

  assign bot_p = $signed({{(BASE_W-EXP_W){1'b0}}, a.exp})
               + $signed({{(BASE_W-EXP_W){1'b0}}, b.exp}) - PROD_OFF;
  assign bot_c = $signed({{(BASE_W-EXP_W){1'b0}}, c.exp}) - C_OFF;

  // A zero operand borrows the other's weight so it never forces a shift.
  assign bot_p_e = (prod == '0)  ? bot_c   : bot_p;
  assign bot_c_e = (sig_c == '0) ? bot_p_e : bot_c;
  assign diff    = bot_p_e - bot_c_e;

  assign term_p = (a.sign ^ b.sign) ? (ACC_W'(0) - ACC_W'(prod)) : ACC_W'(prod);
  assign term_c = c.sign ? (ACC_W'(0) - ACC_W'(sig_c)) : ACC_W'(sig_c);

  always_comb begin
    if (diff > LIM_S) begin
      acc  = term_p;
      base = bot_p_e;
    end else if (diff >= 0) begin
      acc  = (term_p << $unsigned(diff)) + term_c;
      base = bot_c_e;
    end else if (-diff > LIM_S) begin
      acc  = term_c;
      base = bot_c_e;
    end else begin
      acc  = term_p + (term_c << $unsigned(-diff));
      base = bot_p_e;
    end
  end

  assign neg = acc[ACC_W-1];
  assign mag = neg ? (ACC_W'(0) - acc) : acc;

  always_comb begin
    lead = 0;
    for (int i = 0; i < ACC_W; i++) begin
      if (mag[i]) lead = i;
    end
  end

  assign e_res = int'(base) + lead + EXP_BIAS;

  always_comb begin
    y = '0;
    if (mag == '0 || e_res <= 0) begin
      y = '0;
    end else if (e_res >= (1 << EXP_W) - 1) begin
      y.sign = neg;
      y.exp  = EXP_W'((1 << EXP_W) - 2);
      y.man  = '1;
    end else begin
      y.sign = neg;
      y.exp  = EXP_W'(e_res);
      if (lead >= MAN_W) y.man = MAN_W'(mag >> (lead - MAN_W));
      else               y.man = MAN_W'(mag << (MAN_W - lead));
    end
  end
endmodule

// File: rtl/score_bank.sv
// One score register per frame; one read port for accumulate, one for drain.
module score_bank
  import wsa_pkg::*;
#(
  parameter int NUM_FRAMES = 10,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  rfloat_t          wr_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  output rfloat_t          rd_data_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output rfloat_t          rd_data_b
);
  rfloat_t regs [NUM_FRAMES];

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)                                      regs[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))        regs[g] <= wr_data;
    end
  end

  assign rd_data_a = regs[rd_idx_a];
  assign rd_data_b = regs[rd_idx_b];
endmodule

// File: rtl/result_fifo.sv
// Show-ahead FIFO; the array has no reset so it maps to distributed RAM.
module result_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic [WIDTH-1:0]              push_data,
  input  logic                          pop,
  output logic [WIDTH-1:0]              pop_data,
  output logic                          empty,
  output logic [$clog2(DEPTH+1)-1:0]    free_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_pop;

  assign do_pop = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(do_pop);
    end
  end

  assign pop_data = mem[rd_ptr];
  assign empty    = (count == '0);
  assign free_cnt = CW'(DEPTH) - count;
endmodule

// File: rtl/weighted_score_acc.sv
module weighted_score_acc
  import wsa_pkg::*;
#(
  parameter int NUM_FRAMES = 10,
  parameter int NUM_COMPS  = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int ALIGN_LIM  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FP_W-1:0]   in_sum,
  input  logic [FP_W-1:0]   in_scale,
  input  logic [FP_W-1:0]   in_weight,
  input  logic              out_pop,
  output logic              out_empty,
  output logic [IEEE_W-1:0] out_data
);
  localparam int FIDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam int CIDX_W = (NUM_COMPS > 1) ? $clog2(NUM_COMPS) : 1;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam logic [FIDX_W-1:0] LAST_FRAME = FIDX_W'(NUM_FRAMES - 1);
  localparam logic [CIDX_W-1:0] LAST_COMP  = CIDX_W'(NUM_COMPS - 1);
  localparam logic [CNT_W-1:0]  GROUP_ROOM = CNT_W'(NUM_FRAMES);

  seq_state_t        state_q;
  logic [FIDX_W-1:0] frame_q, drain_q;
  logic [CIDX_W-1:0] comp_q;
  logic              accept, group_start;

  rfloat_t           coef_scale_q, coef_wt_q, cur_scale, cur_wt;

  logic              s1_vld, s2_vld, s1_first, s2_first;
  rfloat_t           s1_sum, s1_scale, s1_wt, s2_p;
  logic [FIDX_W-1:0] s1_frame, s2_frame;

  rfloat_t           p_y, acc_c, acc_y, bank_a, bank_b;
  logic              fifo_push;
  logic [CNT_W-1:0]  fifo_free;

  // ---------------- input acceptance ----------------
  assign group_start = (frame_q == '0) && (comp_q == '0);
  assign in_ready    = (state_q == ST_ACCUM) && !(group_start && fifo_free < GROUP_ROOM);
  assign accept      = in_valid && in_ready;

  // Scale and weight belong to the component: the frame-0 beat supplies them.
  assign cur_scale = (frame_q == '0) ? rfloat_t'(in_scale)  : coef_scale_q;
  assign cur_wt    = (frame_q == '0) ? rfloat_t'(in_weight) : coef_wt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      coef_scale_q <= '0;
      coef_wt_q    <= '0;
    end else if (accept && frame_q == '0) begin
      coef_scale_q <= rfloat_t'(in_scale);
      coef_wt_q    <= rfloat_t'(in_weight);
    end
  end

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ACCUM;
      frame_q <= '0;
      comp_q  <= '0;
      drain_q <= '0;
    end else begin
      case (state_q)
        ST_ACCUM: if (accept) begin
          if (frame_q == LAST_FRAME) begin
            frame_q <= '0;
            if (comp_q == LAST_COMP) begin
              comp_q  <= '0;
              state_q <= ST_FLUSH;
            end else begin
              comp_q <= comp_q + 1'b1;
            end
          end else begin
            frame_q <= frame_q + 1'b1;
          end
        end
        ST_FLUSH: if (!s1_vld && !s2_vld) begin
          state_q <= ST_DRAIN;
          drain_q <= '0;
        end
        ST_DRAIN: begin
          if (drain_q == LAST_FRAME) state_q <= ST_ACCUM;
          else                       drain_q <= drain_q + 1'b1;
        end
        default: state_q <= ST_ACCUM;
      endcase
    end
  end

  // ---------------- stage 1: operand capture, loads only on a beat ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_sum   <= '0;
      s1_scale <= '0;
      s1_wt    <= '0;
      s1_frame <= '0;
      s1_first <= 1'b0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_sum   <= rfloat_t'(in_sum);
        s1_scale <= cur_scale;
        s1_wt    <= cur_wt;
        s1_frame <= frame_q;
        s1_first <= (comp_q == '0);
      end
    end
  end

  // ---------------- stage 2: scaled and weighted term ----------------
  rf_fma #(.ALIGN_LIM(ALIGN_LIM)) term_fma_i (
    .a(s1_sum), .b(s1_scale), .c(s1_wt), .y(p_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld   <= 1'b0;
      s2_p     <= '0;
      s2_frame <= '0;
      s2_first <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_p     <= p_y;
        s2_frame <= s1_frame;
        s2_first <= s1_first;
      end
    end
  end

  // ---------------- stage 3: accumulate into the frame register ----------------
  assign acc_c = s2_first ? rfloat_t'('0) : bank_a;

  rf_fma #(.ALIGN_LIM(ALIGN_LIM)) acc_fma_i (
    .a(s2_p), .b(RF_ONE), .c(acc_c), .y(acc_y)
  );

  score_bank #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(FIDX_W)) bank_i (
    .clk(clk), .rst(rst),
    .wr_en(s2_vld), .wr_idx(s2_frame), .wr_data(acc_y),
    .rd_idx_a(s2_frame), .rd_data_a(bank_a),
    .rd_idx_b(drain_q),  .rd_data_b(bank_b)
  );

  // ---------------- result queue ----------------
  assign fifo_push = (state_q == ST_DRAIN);

  result_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(IEEE_W)) fifo_i (
    .clk(clk), .rst(rst),
    .push(fifo_push), .push_data(to_ieee(bank_b)),
    .pop(out_pop), .pop_data(out_data),
    .empty(out_empty), .free_cnt(fifo_free)
  );
endmodule

// File: rtl/wsa_checker.sv
module wsa_checker #(
  parameter int FIDX_W = 4,
  parameter int CNT_W  = 5,
  parameter int FP_W   = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              accept,
  input logic              s1_vld,
  input logic [FP_W-1:0]   s1_sum,
  input logic [FP_W-1:0]   s2_p,
  input logic              fifo_push,
  input logic [CNT_W-1:0]  fifo_free,
  input logic [FIDX_W-1:0] drain_q,
  input logic              out_pop,
  input logic              out_empty
);
  // R7: a result is never written into a full queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> (fifo_free != '0));

  // R8: popping an empty queue leaves it empty
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (out_empty && out_pop && !fifo_push) |=> out_empty);

  // R9: without a beat the capture stage holds its operand
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(s1_sum));

  // R9: the term stage holds when nothing enters it
  p_stage_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> $stable(s2_p));

  // R6: consecutive queue writes walk the frames upward
  p_frame_order_r6: assert property (@(posedge clk) disable iff (rst)
    (fifo_push && $past(fifo_push)) |-> (drain_q == $past(drain_q) + 1'b1));
endmodule

bind weighted_score_acc wsa_checker #(.FIDX_W(FIDX_W), .CNT_W(CNT_W), .FP_W(FP_W)) chk_i (
  .clk(clk), .rst(rst), .accept(accept), .s1_vld(s1_vld),
  .s1_sum(s1_sum), .s2_p(s2_p), .fifo_push(fifo_push), .fifo_free(fifo_free),
  .drain_q(drain_q), .out_pop(out_pop), .out_empty(out_empty)
);

// File: tb/weighted_score_acc_tb_top.sv
module weighted_score_acc_tb_top;
  localparam int NF = 10;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [20:0] in_sum = '0, in_scale = '0, in_weight = '0;
  logic        out_pop = 1'b0;
  logic        out_empty;
  logic [31:0] out_data;

  always #10 clk = ~clk;

  weighted_score_acc dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sum(in_sum), .in_scale(in_scale), .in_weight(in_weight),
    .out_pop(out_pop), .out_empty(out_empty), .out_data(out_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  int g_sum[NC][NF];
  int g_scale[NC];
  int g_wt[NC];

  function automatic int msb_of(int m);
    int k = 0;
    for (int i = 0; i < 31; i++) if (m[i]) k = i;
    return k;
  endfunction

  // R2 input encoding: {sign, exp+127, 12-bit fraction}
  function automatic logic [20:0] enc(int v);
    int m, k;
    logic [11:0] fr;
    if (v == 0) return '0;
    m  = (v < 0) ? -v : v;
    k  = msb_of(m);
    fr = 12'((m << (12 - k)) & 32'hFFF);
    return {(v < 0), 8'(127 + k), fr};
  endfunction

  // R2 output format: IEEE single of an integer
  function automatic logic [31:0] ieee(int v);
    int m, k;
    logic [22:0] fr;
    if (v == 0) return '0;
    m  = (v < 0) ? -v : v;
    k  = msb_of(m);
    fr = 23'((m << (23 - k)) & 32'h7FFFFF);
    return {(v < 0), 8'(127 + k), fr};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic fill_random();
    for (int c = 0; c < NC; c++) begin
      g_scale[c] = int'($urandom_range(15));
      g_wt[c]    = int'($urandom_range(126)) - 63;
      for (int f = 0; f < NF; f++) g_sum[c][f] = int'($urandom_range(63));
    end
  endtask

  task automatic queue_expected();
    for (int f = 0; f < NF; f++) begin
      int s = 0;
      for (int c = 0; c < NC; c++) s += g_sum[c][f] * g_scale[c] + g_wt[c];
      exp_q.push_back(ieee(s));
    end
  endtask

  task automatic send_group(input bit garbage, input int max_gap, input bit chk_flush);
    for (int c = 0; c < NC; c++) begin
      for (int f = 0; f < NF; f++) begin
        int gap = (max_gap > 0) ? int'($urandom_range(max_gap)) : 0;
        repeat (gap) begin
          @(negedge clk);
          in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_sum   = enc(g_sum[c][f]);
        if (garbage && f != 0) begin
          in_scale  = enc(int'($urandom_range(15)) + 1);
          in_weight = enc(int'($urandom_range(100)) - 50);
        end else begin
          in_scale  = enc(g_scale[c]);
          in_weight = enc(g_wt[c]);
        end
        while (!in_ready) @(negedge clk);
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    // R7: input is held off right after the last beat of a group
    if (chk_flush) check("R7 ready during flush", {31'b0, in_ready}, 32'd0);
  endtask

  task automatic pop_one(input string req);
    int t = 0;
    @(negedge clk);
    while (out_empty && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(req, out_data, exp_q.pop_front());
    out_pop = 1'b1;
    @(negedge clk);
    out_pop = 1'b0;
  endtask

  task automatic drain_all(input string req);
    while (exp_q.size() > 0) pop_one(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2417));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 empty after reset", {31'b0, out_empty}, 32'd1);
    check("R11 ready after reset", {31'b0, in_ready}, 32'd1);

    // R8 pop on an empty queue has no effect
    out_pop = 1'b1;
    repeat (3) @(negedge clk);
    out_pop = 1'b0;
    check("R8 empty after idle pops", {31'b0, out_empty}, 32'd1);

    // R1 R3 R6 random group, back-to-back beats
    fill_random(); queue_expected();
    send_group(1'b0, 0, 1'b1);
    drain_all("R1 R3 R6 R8 result");

    // R2 R9 random group with idle gaps
    fill_random(); queue_expected();
    send_group(1'b0, 3, 1'b0);
    drain_all("R2 R9 result with gaps");

    // R5 scale/weight scrambled after frame 0
    fill_random(); queue_expected();
    send_group(1'b1, 1, 1'b0);
    drain_all("R5 coefficient capture");

    // R10 exact cancellation in frame 0
    fill_random();
    g_wt = '{7, -3, -4, 2, -2, 1, -1, 0};
    for (int c = 0; c < NC; c++) g_sum[c][0] = 0;
    queue_expected();
    send_group(1'b0, 0, 1'b0);
    drain_all("R10 cancellation");

    // R10 negative totals
    fill_random();
    for (int c = 0; c < NC; c++) begin
      g_wt[c] = -63;
      for (int f = 0; f < NF; f++) g_sum[c][f] = int'($urandom_range(3));
    end
    queue_expected();
    send_group(1'b0, 0, 1'b0);
    drain_all("R10 negative");

    // R4 following group must not see stale scores
    fill_random(); queue_expected();
    send_group(1'b0, 2, 1'b0);
    drain_all("R4 fresh group");

    // R7 back-pressure with a partly full queue
    fill_random(); queue_expected();
    send_group(1'b0, 0, 1'b0);
    repeat (25) @(negedge clk);
    check("R7 ready with six free", {31'b0, in_ready}, 32'd0);
    in_valid  = 1'b1;
    in_sum    = enc(50);
    in_scale  = enc(9);
    in_weight = enc(-40);
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) pop_one("R7 head while stalled");
    @(negedge clk);
    check("R7 ready after room", {31'b0, in_ready}, 32'd1);
    fill_random(); queue_expected();
    send_group(1'b0, 0, 1'b0);
    drain_all("R7 after stall");

    check("R8 empty at end", {31'b0, out_empty}, 32'd1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule